// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the configuration header of one target function on a parallel local bus. A configuration access port selects one of sixteen dwords by index. Each write is masked per byte. Reads are combinational from the selected index. The header carries the read-only identification and class words, a command word, a status word, one memory window base register, one I/O window base register, and the interrupt routing bytes.

The command word drives three enable outputs: memory decoding, I/O decoding and bus mastering. These are used by the address decoder and the initiator logic around the block. Five single-cycle error-event inputs set sticky status flags. Software clears a flag by writing a 1 to it.

Firmware finds the size of each window by writing all ones to a base register and reading back the mask. The address bits below the window size are hardwired to zero, and the type bits are fixed.

Top module: `pci_cfg_regs`

## Requirements
- R1: After reset the command word is 0, both base registers hold only their fixed bits, all status flags are 0, the interrupt line byte is 0, and io_en, mem_en and master_en are 0.
- R2: Dword 0 reads {DEV_ID, VEN_ID} (unit ID in bits 31:16, manufacturer ID in bits 15:0), and writes to it have no effect.
- R3: In dword 1, command bit 0 is the I/O enable, bit 1 the memory enable, bit 2 the bus master enable, bit 6 the parity response enable and bit 8 the system error enable. All other command bits read 0. io_en, mem_en and master_en follow bits 0, 1 and 2 one cycle after the write.
- R4: A write changes only the bytes whose byte enable is 1. When cfg_wr is 0, no register changes.
- R5: The memory base at dword 4 reads bit 0 = 0, bits 2:1 = MEM_TYPE, bit 3 = MEM_PREFETCH, and bits MEM_SZ-1:4 = 0. Bits 31:MEM_SZ are writable, so writing all ones returns the size mask with the fixed bits.
- R6: The I/O base at dword 5 reads bit 0 = 1 and bits IO_SZ-1:1 = 0. Bits 31:IO_SZ are writable.
- R7: Status flags sit in dword bits 31 (parity error detected), 30 (system error signalled), 29 (master abort received), 28 (target abort received) and 27 (target abort signalled). Each flag is set the cycle after its event input is high, and it stays set until it is cleared.
- R8: A flag clears only when dword 1 is written with byte enable 3 high and a 1 in the flag's bit. An event in the same cycle as the clear leaves the flag set.
- R9: The device select timing field in dword bits 26:25 always reads DEVSEL_TIMING (0 fast, 1 medium, 2 slow) and cannot be written.
- R10: Dwords 3, 6 to 14 read 0, and writes to them have no effect.
- R11: Dword 2 reads {CLASS_CODE, REV_ID} and is read-only. Dword 15 reads {MAX_LAT, MIN_GNT, INT_PIN, interrupt line}, and only the interrupt line byte (bits 7:0) is writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idx | input | 4 | Dword index of the access |
| cfg_be | input | 4 | Byte enables of a write |
| cfg_wdata | input | 32 | Write data |
| cfg_wr | input | 1 | Write strobe, one write per high cycle |
| cfg_rdata | output | 32 | Read data of the indexed dword |
| ev_parity_err | input | 1 | Parity error detected event |
| ev_serr_sig | input | 1 | System error signalled event |
| ev_master_abort | input | 1 | Master abort received event |
| ev_tabort_rcv | input | 1 | Target abort received event |
| ev_tabort_sig | input | 1 | Target abort signalled event |
| io_en | output | 1 | I/O window decode enable |
| mem_en | output | 1 | Memory window decode enable |
| master_en | output | 1 | Bus master enable |

## Verification
Any wrong register bit shows on cfg_rdata as soon as its dword is indexed, with no delay, because reads are combinational. A wrong command bit also shows on the enable outputs in the cycle after the write. The sizing readback exposes hardwired bits that were wrongly made writable and writable bits that were wrongly hardwired. Status mistakes, such as a lost event, a flag that clears by itself, a clear applied without its byte enable, or a clear that beats a same-cycle event, each show in the next read of dword 1.

// File: rtl/pci_cfg_regs.sv
module pci_cfg_regs #(
  parameter logic [15:0] VEN_ID        = 16'h1D0C,
  parameter logic [15:0] DEV_ID        = 16'h7A31,
  parameter logic [7:0]  REV_ID        = 8'h02,
  parameter logic [23:0] CLASS_CODE    = 24'h058000,
  parameter int          MEM_SZ        = 12,
  parameter logic        MEM_PREFETCH  = 1'b1,
  parameter logic [1:0]  MEM_TYPE      = 2'b00,
  parameter int          IO_SZ         = 5,
  parameter logic [1:0]  DEVSEL_TIMING = 2'b01,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GNT       = 8'h04,
  parameter logic [7:0]  MAX_LAT       = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  cfg_idx,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  input  logic        cfg_wr,
  output logic [31:0] cfg_rdata,
  input  logic        ev_parity_err,
  input  logic        ev_serr_sig,
  input  logic        ev_master_abort,
  input  logic        ev_tabort_rcv,
  input  logic        ev_tabort_sig,
  output logic        io_en,
  output logic        mem_en,
  output logic        master_en
);

  localparam logic [3:0]  IDX_ID   = 4'd0;
  localparam logic [3:0]  IDX_CS   = 4'd1;
  localparam logic [3:0]  IDX_CLS  = 4'd2;
  localparam logic [3:0]  IDX_MEM  = 4'd4;
  localparam logic [3:0]  IDX_IO   = 4'd5;
  localparam logic [3:0]  IDX_INT  = 4'd15;
  localparam logic [15:0] CMD_MASK = 16'h0147;
  localparam logic [31:0] MEM_MASK = 32'hFFFF_FFFF << MEM_SZ;
  localparam logic [31:0] IO_MASK  = 32'hFFFF_FFFF << IO_SZ;
  localparam logic [31:0] MEM_FIX  = {28'h0, MEM_PREFETCH, MEM_TYPE, 1'b0};
  localparam logic [31:0] IO_FIX   = 32'h0000_0001;

  logic [15:0] cmd_q;
  logic [4:0]  stat_q;
  logic [31:0] mem_q, io_q;
  logic [7:0]  int_line_q;

  wire [31:0] wm = {{8{cfg_be[3]}}, {8{cfg_be[2]}}, {8{cfg_be[1]}}, {8{cfg_be[0]}}};
  wire        wr_cs  = cfg_wr && cfg_idx == IDX_CS;
  wire        wr_mem = cfg_wr && cfg_idx == IDX_MEM;
  wire        wr_io  = cfg_wr && cfg_idx == IDX_IO;
  wire        wr_int = cfg_wr && cfg_idx == IDX_INT && cfg_be[0];
  wire [4:0]  ev  = {ev_parity_err, ev_serr_sig, ev_master_abort, ev_tabort_rcv, ev_tabort_sig};
  wire [4:0]  clr = (wr_cs && cfg_be[3]) ? cfg_wdata[31:27] : 5'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      stat_q     <= '0;
      mem_q      <= '0;
      io_q       <= '0;
      int_line_q <= '0;
    end else begin
      if (wr_cs)
        cmd_q <= ((cmd_q & ~wm[15:0]) | (cfg_wdata[15:0] & wm[15:0])) & CMD_MASK;
      if (wr_mem)
        mem_q <= ((mem_q & ~wm) | (cfg_wdata & wm)) & MEM_MASK;
      if (wr_io)
        io_q <= ((io_q & ~wm) | (cfg_wdata & wm)) & IO_MASK;
      if (wr_int)
        int_line_q <= cfg_wdata[7:0];
      stat_q <= (stat_q & ~clr) | ev;
    end
  end

  assign io_en     = cmd_q[0];
  assign mem_en    = cmd_q[1];
  assign master_en = cmd_q[2];

  always_comb begin
    case (cfg_idx)
      IDX_ID:  cfg_rdata = {DEV_ID, VEN_ID};
      IDX_CS:  cfg_rdata = {stat_q, DEVSEL_TIMING, 9'h0, cmd_q};
      IDX_CLS: cfg_rdata = {CLASS_CODE, REV_ID};
      IDX_MEM: cfg_rdata = mem_q | MEM_FIX;
      IDX_IO:  cfg_rdata = io_q | IO_FIX;
      IDX_INT: cfg_rdata = {MAX_LAT, MIN_GNT, INT_PIN, int_line_q};
      default: cfg_rdata = '0;
    endcase
  end

  // R7: an event leaves its flag set in the next cycle, whatever the write
  p_ev_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev != 5'b0 |=> (stat_q & $past(ev)) == $past(ev));

  // R8: without an enabled write to byte 3 of dword 1, no flag falls
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_idx == IDX_CS && cfg_be[3]) |=> (stat_q & $past(stat_q)) == $past(stat_q));

  // R3: the I/O enable output follows the written command bit 0
  p_cmd_io_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_idx == IDX_CS && cfg_be[0] |=> io_en == $past(cfg_wdata[0]));

  // R5: the writable memory base bits take the written value
  p_membar_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_idx == IDX_MEM && (&cfg_be) |=> mem_q[31:MEM_SZ] == $past(cfg_wdata[31:MEM_SZ]));

  // R4: no write strobe, no change of any writable register
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cmd_q) && $stable(mem_q) && $stable(io_q) && $stable(int_line_q));

endmodule

// File: tb/test_pci_cfg_regs.sv
module test_pci_cfg_regs;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic        wr;
    logic [3:0]  idx;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'd1,  4'h0, 32'h0,         32'h0200_0000, 4'd1},  // R1 reset status/command
    '{1'b0, 4'd4,  4'h0, 32'h0,         32'h0000_0008, 4'd5},  // R5 reset memory base
    '{1'b0, 4'd5,  4'h0, 32'h0,         32'h0000_0001, 4'd6},  // R6 reset I/O base
    '{1'b0, 4'd15, 4'h0, 32'h0,         32'h1004_0100, 4'd11}, // R11 interrupt dword
    '{1'b1, 4'd0,  4'hF, 32'hFFFF_FFFF, 32'h7A31_1D0C, 4'd2},  // R2 IDs read-only
    '{1'b1, 4'd2,  4'hF, 32'hFFFF_FFFF, 32'h0580_0002, 4'd11}, // R11 class read-only
    '{1'b1, 4'd4,  4'hF, 32'hFFFF_FFFF, 32'hFFFF_F008, 4'd5},  // R5 sizing
    '{1'b1, 4'd5,  4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFE1, 4'd6},  // R6 sizing
    '{1'b1, 4'd4,  4'hF, 32'h1234_5678, 32'h1234_5008, 4'd5},  // R5 base value
    '{1'b1, 4'd4,  4'h8, 32'hAABB_CCDD, 32'hAA34_5008, 4'd4},  // R4 byte 3 only
    '{1'b1, 4'd4,  4'h4, 32'h0077_0000, 32'hAA77_5008, 4'd4},  // R4 byte 2 only
    '{1'b1, 4'd1,  4'h1, 32'hFFFF_FFFF, 32'h0200_0047, 4'd3},  // R3 low command byte
    '{1'b1, 4'd1,  4'h3, 32'hFFFF_FFFF, 32'h0200_0147, 4'd3},  // R3 both command bytes
    '{1'b1, 4'd1,  4'hC, 32'h0000_0000, 32'h0200_0147, 4'd9},  // R9 timing field fixed
    '{1'b1, 4'd15, 4'hF, 32'hFFFF_FFAB, 32'h1004_01AB, 4'd11}, // R11 line writable
    '{1'b1, 4'd3,  4'hF, 32'hFFFF_FFFF, 32'h0000_0000, 4'd10}, // R10 dword 3
    '{1'b1, 4'd9,  4'hF, 32'hFFFF_FFFF, 32'h0000_0000, 4'd10}, // R10 dword 9
    '{1'b1, 4'd15, 4'h0, 32'h0000_0000, 32'h1004_01AB, 4'd4},  // R4 no byte enabled
    '{1'b1, 4'd1,  4'h3, 32'h0000_0000, 32'h0200_0000, 4'd3},  // R3 clear command
    '{1'b1, 4'd1,  4'h1, 32'h0000_0005, 32'h0200_0005, 4'd3}   // R3 io + master
  };

  logic clk = 1'b0, rst_n = 1'b0, cfg_wr = 1'b0;
  logic [3:0] cfg_idx = '0, cfg_be = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic ev_pe = 0, ev_se = 0, ev_ma = 0, ev_tr = 0, ev_ts = 0;
  logic io_en, mem_en, master_en;
  int errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  pci_cfg_regs i_pci_cfg_regs (
    .clk(clk), .rst_n(rst_n), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata),
    .ev_parity_err(ev_pe), .ev_serr_sig(ev_se), .ev_master_abort(ev_ma),
    .ev_tabort_rcv(ev_tr), .ev_tabort_sig(ev_ts),
    .io_en(io_en), .mem_en(mem_en), .master_en(master_en));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_be = be; cfg_wdata = wd;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] v);
    cfg_idx = idx;
    #1 v = cfg_rdata;
  endtask

  task automatic pulse(input logic [4:0] e);
    @(negedge clk);
    {ev_pe, ev_se, ev_ma, ev_tr, ev_ts} = e;
    @(negedge clk);
    {ev_pe, ev_se, ev_ma, ev_tr, ev_ts} = '0;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 enables", {29'h0, io_en, mem_en, master_en}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) wr(TBL[i].idx, TBL[i].be, TBL[i].wd);
      else @(negedge clk);
      rd(TBL[i].idx, v);
      chk($sformatf("R%0d vector %0d", TBL[i].req, i), v, TBL[i].exp);
    end
    #1 chk("R3 io+master enables", {29'h0, io_en, mem_en, master_en}, 32'h5);

    wr(4'd1, 4'h3, 32'h0000_0002);
    #1 chk("R3 memory enable only", {29'h0, io_en, mem_en, master_en}, 32'h2);

    pulse(5'b10000);
    rd(4'd1, v); chk("R7 parity flag set", v, 32'h8200_0002);
    repeat (3) @(negedge clk);
    rd(4'd1, v); chk("R7 parity flag sticky", v, 32'h8200_0002);

    wr(4'd1, 4'h8, 32'h4000_0000);
    rd(4'd1, v); chk("R8 other bit clear leaves flag", v, 32'h8200_0002);
    wr(4'd1, 4'h8, 32'h8000_0000);
    rd(4'd1, v); chk("R8 write-1 clears", v, 32'h0200_0002);

    pulse(5'b11111);
    rd(4'd1, v); chk("R7 all flags set", v, 32'hFA00_0002);
    wr(4'd1, 4'h7, 32'hFFFF_FFFF);
    rd(4'd1, v); chk("R8 clear needs byte 3 enable", v, 32'hFA00_0147);
    #1 chk("R3 all enables", {29'h0, io_en, mem_en, master_en}, 32'h7);

    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 4'd1; cfg_be = 4'h8; cfg_wdata = 32'hF800_0000; ev_ma = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0; ev_ma = 1'b0;
    rd(4'd1, v); chk("R8 event beats clear", v, 32'h2200_0147);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(4'd4, v); chk("R1 memory base after reset", v, 32'h0000_0008);
    rd(4'd1, v); chk("R1 status/command after reset", v, 32'h0200_0000);
    rd(4'd15, v); chk("R1 interrupt line after reset", v, 32'h1004_0100);
    chk("R1 enables after reset", {29'h0, io_en, mem_en, master_en}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule